// File: doc/BRIEF.md
# Trace Late-Data Merge Unit

This unit sits beside a trace buffer whose command entries are written the moment a command is seen, with the fields that depend on later data left at zero. Each traced command that still expects data registers its buffer index and its kind (byte-masked store or DMA) with the unit. The data beats that belong to those commands arrive later, in the same order as the commands. The unit folds every valid beat of the current command into a summary field and, on the end-of-write beat, issues a patch write that fills the summary into the entry at the recorded index.

The buffer port is shared with command writes, which always win. A finished patch goes straight to the port in the cycle it completes if the port is free and nothing older is waiting; otherwise it is parked in a shallow queue that drains, oldest first, in every cycle the port is free. The queue never stalls the data stream: when it is full and another patch completes, the oldest parked patch is discarded, so its trace entry keeps zeros in its late fields. Commands whose data must be consumed but not recorded (responses and untraced traffic) are registered with a discard flag so that the data stream stays aligned with the command stream.

Top module: `late_merge`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `patch_valid` is 0.
- R2: For a store command the patch field has bit k (k = 0..7) set exactly when at least one valid beat of that command carried `beat_sub` = k and a nonzero `beat_mask`.
- R3: For a DMA command the patch field holds the `beat_sub` of the command's first valid beat in bits [7:5] and the number of valid beats, saturated at 31, in bits [4:0].
- R4: Patches carry the buffer indices of the registered commands in the order the commands were registered; a beat belongs to the oldest registered command not yet closed by an end-of-write beat, and must arrive at least one cycle after that command was registered.
- R5: A command registered with `cmd_keep` = 0 consumes its beats up to its end-of-write beat but produces no patch.
- R6: In a cycle with `buf_busy` = 1, `patch_valid` is 0.
- R7: When a patch completes in a cycle with `buf_busy` = 0 and no parked patch, it appears on the patch outputs in that same cycle.
- R8: In every cycle with `buf_busy` = 0 and at least one parked patch, the oldest parked patch is written; a patch completing in that cycle is parked behind it.
- R9: At most 4 patches (the parameter default) are parked; a completion that would exceed this discards the oldest parked patch, and the survivors drain in completion order.
- R10: Beats with `beat_valid` = 0, and valid beats while no command is registered, change neither the outputs nor any later patch.
- R11: The summary restarts from empty for each command; nothing of one command's beats appears in the next command's patch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_push | input | 1 | Registers a command that expects data beats |
| cmd_idx | input | 6 | Trace buffer index of that command's entry |
| cmd_keep | input | 1 | 1: patch the entry; 0: consume beats only |
| cmd_kind | input | 1 | 0: store (byte-mask summary); 1: DMA (address and length) |
| beat_valid | input | 1 | A data beat is present |
| beat_eow | input | 1 | This beat is the last of its command |
| beat_sub | input | 3 | Sub-block number of the beat within a 128-byte line |
| beat_mask | input | 16 | Byte write mask of the beat |
| buf_busy | input | 1 | The buffer port is taken by a command write this cycle |
| patch_valid | output | 1 | A patch write is issued this cycle |
| patch_idx | output | 6 | Buffer index the patch applies to |
| patch_field | output | 8 | Late-field value written into that entry |

## Verification
A stale or skipped entry in the pending-command queue shows at the ports as a patch carrying the index of a neighbouring command, on the very next end-of-write beat. An accumulator that fails to clear, or merges a beat twice, corrupts the field of the next patch, visible in the cycle that patch is issued. A wrong count or pointer in the parking queue shows either as a patch emitted during a busy cycle, a missing write in the first free cycle, or the wrong survivor order after an overflow, all within one free cycle of the fault.

// File: rtl/late_merge_pkg.sv
`timescale 1ns/1ps
package late_merge_pkg;
    localparam int SUB_W_DEF  = 3;
    localparam int MASK_W_DEF = 16;

    typedef enum logic {
        KIND_STORE = 1'b0,
        KIND_DMA   = 1'b1
    } merge_kind_e;
endpackage

// File: rtl/late_merge_pending.sv
`timescale 1ns/1ps
// In-order record of commands still waiting for their data beats.
module late_merge_pending #(
    parameter int IDX_W = 6,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [IDX_W-1:0] push_idx,
    input  logic             push_keep,
    input  logic             push_kind,
    input  logic             pop,
    output logic [IDX_W-1:0] head_idx,
    output logic             head_keep,
    output logic             head_kind,
    output logic             not_empty,
    output logic [$clog2(DEPTH):0] count
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int ENT_W = IDX_W + 2;

    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [PTR_W:0]   cnt;
    } ptr_t;

    ptr_t             st_d, st_q;
    logic [ENT_W-1:0] mem_d [DEPTH];
    logic [ENT_W-1:0] mem_q [DEPTH];
    logic             do_push, do_pop;

    assign do_pop  = pop && (st_q.cnt != '0);
    assign do_push = push && (st_q.cnt != (PTR_W+1)'(DEPTH));

    always_comb begin
        st_d  = st_q;
        mem_d = mem_q;
        if (do_push) begin
            mem_d[st_q.wr] = {push_kind, push_keep, push_idx};
            st_d.wr        = st_q.wr + 1'b1;
        end
        if (do_pop) begin
            st_d.rd = st_q.rd + 1'b1;
        end
        st_d.cnt = st_q.cnt + (PTR_W+1)'(do_push) - (PTR_W+1)'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            st_q  <= st_d;
            mem_q <= mem_d;
        end
    end

    assign {head_kind, head_keep, head_idx} = mem_q[st_q.rd];
    assign not_empty = (st_q.cnt != '0);
    assign count     = st_q.cnt;
endmodule

// File: rtl/late_merge_accum.sv
`timescale 1ns/1ps
// Folds the valid beats of one command into its late-field summary.
module late_merge_accum
    import late_merge_pkg::*;
#(
    parameter int SUB_W  = SUB_W_DEF,
    parameter int MASK_W = MASK_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    beat_ok,
    input  logic                    beat_eow,
    input  logic [SUB_W-1:0]        beat_sub,
    input  logic [MASK_W-1:0]       beat_mask,
    input  merge_kind_e             kind,
    output logic [(1<<SUB_W)-1:0]   field,
    output logic                    idle
);
    localparam int FIELD_W = 1 << SUB_W;
    localparam int LEN_W   = FIELD_W - SUB_W;
    localparam logic [LEN_W-1:0] LEN_MAX = '1;

    typedef struct packed {
        logic [FIELD_W-1:0] mask;
        logic [LEN_W-1:0]   len;
        logic [SUB_W-1:0]   sub;
        logic               idle;
    } acc_t;

    localparam acc_t ACC_EMPTY = '{mask: '0, len: '0, sub: '0, idle: 1'b1};

    acc_t               st_d, st_q;
    logic [FIELD_W-1:0] mask_m;
    logic [LEN_W-1:0]   len_m;
    logic [SUB_W-1:0]   sub_m;

    always_comb begin
        mask_m = st_q.mask;
        len_m  = st_q.len;
        sub_m  = st_q.sub;
        if (beat_ok) begin
            if (beat_mask != '0) mask_m = st_q.mask | (FIELD_W'(1) << beat_sub);
            if (st_q.len != LEN_MAX) len_m = st_q.len + 1'b1;
            if (st_q.idle) sub_m = beat_sub;
        end

        field = (kind == KIND_DMA) ? {sub_m, len_m} : mask_m;

        st_d = st_q;
        if (beat_ok) begin
            if (beat_eow) begin
                st_d = ACC_EMPTY;
            end else begin
                st_d.mask = mask_m;
                st_d.len  = len_m;
                st_d.sub  = sub_m;
                st_d.idle = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ACC_EMPTY;
        else        st_q <= st_d;
    end

    assign idle = st_q.idle;
endmodule

// File: rtl/late_merge_park.sv
`timescale 1ns/1ps
// Shallow parking queue for finished patches; overwrites the oldest when full.
module late_merge_park #(
    parameter int ENT_W = 14,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [ENT_W-1:0] push_ent,
    input  logic             pop,
    output logic [ENT_W-1:0] head_ent,
    output logic [$clog2(DEPTH):0] count
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W:0] FULL = (PTR_W+1)'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [PTR_W:0]   cnt;
    } ptr_t;

    ptr_t             st_d, st_q;
    logic [ENT_W-1:0] mem_d [DEPTH];
    logic [ENT_W-1:0] mem_q [DEPTH];
    logic             do_pop, overwrite;

    assign do_pop    = pop && (st_q.cnt != '0);
    assign overwrite = push && !do_pop && (st_q.cnt == FULL);

    always_comb begin
        st_d  = st_q;
        mem_d = mem_q;
        if (push) begin
            mem_d[st_q.wr] = push_ent;
            st_d.wr        = st_q.wr + 1'b1;
        end
        if (do_pop || overwrite) begin
            st_d.rd = st_q.rd + 1'b1;
        end
        if (!overwrite) begin
            st_d.cnt = st_q.cnt + (PTR_W+1)'(push) - (PTR_W+1)'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            st_q  <= st_d;
            mem_q <= mem_d;
        end
    end

    assign head_ent = mem_q[st_q.rd];
    assign count    = st_q.cnt;
endmodule

// File: rtl/late_merge.sv
`timescale 1ns/1ps
module late_merge
    import late_merge_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int QDEPTH = 8,
    parameter int FDEPTH = 4,
    parameter int SUB_W  = SUB_W_DEF,
    parameter int MASK_W = MASK_W_DEF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_push,
    input  logic [IDX_W-1:0]      cmd_idx,
    input  logic                  cmd_keep,
    input  logic                  cmd_kind,
    input  logic                  beat_valid,
    input  logic                  beat_eow,
    input  logic [SUB_W-1:0]      beat_sub,
    input  logic [MASK_W-1:0]     beat_mask,
    input  logic                  buf_busy,
    output logic                  patch_valid,
    output logic [IDX_W-1:0]      patch_idx,
    output logic [(1<<SUB_W)-1:0] patch_field
);
    localparam int FIELD_W = 1 << SUB_W;
    localparam int ENT_W   = IDX_W + FIELD_W;

    logic [IDX_W-1:0]        head_idx;
    logic                    head_keep, head_kind, pend_any;
    logic [$clog2(QDEPTH):0] pend_cnt;
    logic [$clog2(FDEPTH):0] park_cnt;
    logic [FIELD_W-1:0]      merged;
    logic [ENT_W-1:0]        park_head, new_ent;
    logic                    acc_idle, beat_ok, beat_done, new_patch;
    logic                    park_pop, bypass, park_push;

    assign beat_ok   = beat_valid && pend_any;
    assign beat_done = beat_ok && beat_eow;
    assign new_patch = beat_done && head_keep;

    late_merge_pending #(.IDX_W(IDX_W), .DEPTH(QDEPTH)) u_pend (
        .clk(clk), .rst_n(rst_n),
        .push(cmd_push), .push_idx(cmd_idx), .push_keep(cmd_keep), .push_kind(cmd_kind),
        .pop(beat_done),
        .head_idx(head_idx), .head_keep(head_keep), .head_kind(head_kind),
        .not_empty(pend_any), .count(pend_cnt)
    );

    late_merge_accum #(.SUB_W(SUB_W), .MASK_W(MASK_W)) u_acc (
        .clk(clk), .rst_n(rst_n),
        .beat_ok(beat_ok), .beat_eow(beat_eow), .beat_sub(beat_sub), .beat_mask(beat_mask),
        .kind(merge_kind_e'(head_kind)), .field(merged), .idle(acc_idle)
    );

    assign new_ent   = {head_idx, merged};
    assign park_pop  = !buf_busy && (park_cnt != '0);
    assign bypass    = !buf_busy && (park_cnt == '0) && new_patch;
    assign park_push = new_patch && !bypass;

    late_merge_park #(.ENT_W(ENT_W), .DEPTH(FDEPTH)) u_park (
        .clk(clk), .rst_n(rst_n),
        .push(park_push), .push_ent(new_ent), .pop(park_pop),
        .head_ent(park_head), .count(park_cnt)
    );

    assign patch_valid = park_pop || bypass;
    assign {patch_idx, patch_field} = park_pop ? park_head : new_ent;
endmodule

module late_merge_chk #(
    parameter int QDEPTH = 8,
    parameter int FDEPTH = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    buf_busy,
    input logic                    patch_valid,
    input logic                    beat_done,
    input logic                    head_keep,
    input logic                    acc_idle,
    input logic [$clog2(QDEPTH):0] pend_cnt,
    input logic [$clog2(FDEPTH):0] park_cnt
);
    // R6: the command write owns the port
    a_r6_no_patch_busy: assert property (@(posedge clk) disable iff (!rst_n)
        buf_busy |-> !patch_valid);
    // R8: a free port with parked work is always used
    a_r8_drain_free: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_busy && park_cnt != '0) |-> patch_valid);
    // R9: parking depth bound
    a_r9_park_bound: assert property (@(posedge clk) disable iff (!rst_n)
        park_cnt <= ($clog2(FDEPTH)+1)'(FDEPTH));
    // R4: pending record bound
    a_r4_pend_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pend_cnt <= ($clog2(QDEPTH)+1)'(QDEPTH));
    // R5: a discarded command never reaches the port directly
    a_r5_discard: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_done && !head_keep && park_cnt == '0) |-> !patch_valid);
    // R11: summary restarts after each end-of-write
    a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
        beat_done |=> acc_idle);
endmodule

bind late_merge late_merge_chk #(.QDEPTH(QDEPTH), .FDEPTH(FDEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .buf_busy(buf_busy), .patch_valid(patch_valid),
    .beat_done(beat_done), .head_keep(head_keep), .acc_idle(acc_idle),
    .pend_cnt(pend_cnt), .park_cnt(park_cnt)
);

// File: tb/late_merge_bench.sv
`timescale 1ns/1ps
module late_merge_bench;
    localparam int QDEPTH = 8;
    localparam int FDEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_push, cmd_keep, cmd_kind;
    logic [5:0]  cmd_idx;
    logic        beat_valid, beat_eow, buf_busy;
    logic [2:0]  beat_sub;
    logic [15:0] beat_mask;
    logic        patch_valid;
    logic [5:0]  patch_idx;
    logic [7:0]  patch_field;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    late_merge u_late_merge (
        .clk(clk), .rst_n(rst_n),
        .cmd_push(cmd_push), .cmd_idx(cmd_idx), .cmd_keep(cmd_keep), .cmd_kind(cmd_kind),
        .beat_valid(beat_valid), .beat_eow(beat_eow), .beat_sub(beat_sub), .beat_mask(beat_mask),
        .buf_busy(buf_busy),
        .patch_valid(patch_valid), .patch_idx(patch_idx), .patch_field(patch_field)
    );

    // reference model state
    int       mq_idx[$];
    bit       mq_keep[$];
    bit       mq_kind[$];
    bit [7:0] m_mask;
    int       m_len;
    bit [2:0] m_sub;
    bit       m_idle;
    bit [13:0] m_park[$];

    function automatic bit [7:0] store_fold(bit [7:0] acc, bit [2:0] sub, bit [15:0] msk);
        return (msk != 0) ? (acc | (8'd1 << sub)) : acc;
    endfunction

    function automatic bit [7:0] dma_field(bit [2:0] sub, int len);
        return {sub, 5'(len)};
    endfunction

    task automatic model_reset();
        mq_idx.delete(); mq_keep.delete(); mq_kind.delete(); m_park.delete();
        m_mask = 0; m_len = 0; m_sub = 0; m_idle = 1;
    endtask

    task automatic check(string tag, bit ev, bit [5:0] ei, bit [7:0] ef);
        n_checks++;
        if (patch_valid !== ev || (ev && (patch_idx !== ei || patch_field !== ef))) begin
            n_fail++;
            $display("FAIL %s: valid/idx/field got %0b/%0d/%02h expected %0b/%0d/%02h",
                     tag, patch_valid, patch_idx, patch_field, ev, ei, ef);
        end
    endtask

    // compare outputs with the model for the inputs now applied, then advance one cycle
    task automatic cyc(string tag);
        bit ok, done, newp, ev;
        bit [7:0] nm, fld;
        int nl;
        bit [2:0] ns;
        bit [13:0] ne, exp_e;
        #2;
        ok   = beat_valid && (mq_idx.size() > 0);
        done = ok && beat_eow;
        nm = m_mask; nl = m_len; ns = m_sub;
        if (ok) begin
            nm = store_fold(m_mask, beat_sub, beat_mask);
            nl = (m_len < 31) ? m_len + 1 : 31;
            ns = m_idle ? beat_sub : m_sub;
        end
        fld  = (mq_idx.size() > 0 && mq_kind[0]) ? dma_field(ns, nl) : nm;
        newp = done && mq_keep[0];
        ne   = newp ? {6'(mq_idx[0]), fld} : 14'd0;
        ev   = !buf_busy && (m_park.size() > 0 || newp);
        exp_e = (m_park.size() > 0) ? m_park[0] : ne;
        check(tag, ev, exp_e[13:8], exp_e[7:0]);
        if (!buf_busy && m_park.size() > 0) begin
            void'(m_park.pop_front());
            if (newp) m_park.push_back(ne);
        end else if (newp && buf_busy) begin
            m_park.push_back(ne);
        end
        if (m_park.size() > FDEPTH) void'(m_park.pop_front());
        if (ok) begin
            if (beat_eow) begin
                m_mask = 0; m_len = 0; m_sub = 0; m_idle = 1;
                void'(mq_idx.pop_front()); void'(mq_keep.pop_front()); void'(mq_kind.pop_front());
            end else begin
                m_mask = nm; m_len = nl; m_sub = ns; m_idle = 0;
            end
        end
        if (cmd_push && mq_idx.size() < QDEPTH) begin
            mq_idx.push_back(int'(cmd_idx)); mq_keep.push_back(cmd_keep); mq_kind.push_back(cmd_kind);
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_in();
        cmd_push = 0; cmd_idx = 0; cmd_keep = 0; cmd_kind = 0;
        beat_valid = 0; beat_eow = 0; beat_sub = 0; beat_mask = 0; buf_busy = 0;
    endtask

    task automatic push_cmd(bit [5:0] idx, bit keep, bit kind, string tag);
        idle_in(); cmd_push = 1; cmd_idx = idx; cmd_keep = keep; cmd_kind = kind;
        cyc(tag);
    endtask

    task automatic beat(bit v, bit eow, bit [2:0] sub, bit [15:0] msk, bit busy, string tag);
        idle_in(); beat_valid = v; beat_eow = eow; beat_sub = sub; beat_mask = msk; buf_busy = busy;
        cyc(tag);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        idle_in();
        model_reset();
        rst_n = 0;
        @(negedge clk);
        check("R1", 0, 0, 0);
        @(negedge clk);
        check("R1", 0, 0, 0);
        rst_n = 1;
        cyc("R1");

        // R2 and R7: store summary, bypass in completion cycle (expect idx 5, field 8'h44)
        push_cmd(6'd5, 1, 0, "R7");
        beat(1, 0, 3'd2, 16'h0100, 0, "R2");
        beat(0, 0, 3'd4, 16'hFFFF, 0, "R10");
        beat(1, 1, 3'd6, 16'h0001, 0, "R7");
        // R2: zero write mask leaves its sub-block clear (expect field 8'h02)
        push_cmd(6'd6, 1, 0, "R2");
        beat(1, 0, 3'd3, 16'h0000, 0, "R2");
        beat(1, 1, 3'd1, 16'h8000, 0, "R2");

        // R3: DMA first sub 3, three valid beats -> 8'h63
        push_cmd(6'd9, 1, 1, "R3");
        beat(1, 0, 3'd3, 16'h0, 0, "R3");
        beat(1, 0, 3'd5, 16'h0, 0, "R3");
        beat(0, 1, 3'd7, 16'h0, 0, "R10");
        beat(1, 1, 3'd0, 16'h0, 0, "R3");

        // R10: valid beat with nothing registered is ignored
        beat(1, 1, 3'd7, 16'hFFFF, 0, "R10");
        // R11: next command starts clean
        push_cmd(6'd11, 1, 0, "R11");
        beat(1, 1, 3'd0, 16'h0001, 0, "R11");

        // R5: discard command consumes its beats
        push_cmd(6'd20, 0, 0, "R5");
        push_cmd(6'd21, 1, 0, "R5");
        beat(1, 0, 3'd7, 16'h00FF, 0, "R5");
        beat(1, 1, 3'd6, 16'h00FF, 0, "R5");
        beat(1, 1, 3'd1, 16'h0002, 0, "R4");

        // R6, R9, R8: six completions while busy, then drain the last four
        for (int k = 0; k < 6; k++) push_cmd(6'(30 + k), 1, 0, "R4");
        for (int k = 0; k < 6; k++) beat(1, 1, 3'(k), 16'h0001, 1, "R6");
        beat(0, 0, 0, 0, 1, "R6");
        for (int k = 0; k < 5; k++) beat(0, 0, 0, 0, 0, "R9");
        // R8: park two, then complete while draining
        push_cmd(6'd40, 1, 0, "R8");
        push_cmd(6'd41, 1, 0, "R8");
        push_cmd(6'd42, 1, 1, "R8");
        beat(1, 1, 3'd2, 16'h0004, 1, "R8");
        beat(1, 1, 3'd5, 16'h0004, 1, "R8");
        beat(1, 1, 3'd4, 16'h0000, 0, "R8");
        for (int k = 0; k < 3; k++) beat(0, 0, 0, 0, 0, "R8");

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            idle_in();
            if ($urandom_range(0, 2) == 0 && mq_idx.size() < QDEPTH - 1) begin
                cmd_push = 1; cmd_idx = 6'($urandom); cmd_keep = ($urandom_range(0, 4) != 0);
                cmd_kind = 1'($urandom);
            end
            if (mq_idx.size() > 0 && $urandom_range(0, 1) == 0) begin
                beat_valid = ($urandom_range(0, 4) != 0);
                beat_eow   = ($urandom_range(0, 2) == 0);
                beat_sub   = 3'($urandom);
                beat_mask  = ($urandom_range(0, 3) == 0) ? 16'h0 : 16'($urandom);
            end
            buf_busy = ($urandom_range(0, 9) < 4);
            cyc("R4");
        end
        idle_in();
        for (int k = 0; k < 6; k++) cyc("R8");

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
    end
endmodule